// File: doc/BRIEF.md
# Consecutive-Match Threshold Monitor

This block watches the stream of conversion results from an analog-to-digital converter and tracks a single selected channel. Each time a result for that channel arrives, it compares the 12-bit value with a programmed reference. The comparison is either "below the reference" or "at or above the reference". It counts how many results in a row meet that condition. When the run of matches reaches the programmed count plus one, a sticky flag is raised. Software clears the flag by writing 1 to it. An interrupt request follows the flag when the interrupt enable is on.

The comparison can treat both the result and the reference as unsigned numbers or as two's complement numbers. Two instances can be placed side by side to watch two thresholds on their own. Register decoding is handled outside the block, so every setting arrives on a plain input.

Top module: `adc_match_monitor`

## Requirements
- R1: After reset the flag and the interrupt request are 0, and the match counter is 0.
- R2: With `cond_ge` at 0, a result counts as a match when it is strictly less than `ref_val`.
- R3: With `cond_ge` at 1, a result counts as a match when it is greater than or equal to `ref_val`.
- R4: Each matching result on the selected channel adds one to the counter. The flag sets in the cycle after the counter reaches `match_cnt`+1. For example, with `match_cnt`=2 the third consecutive match sets the flag and the second does not.
- R5: A result on the selected channel that does not match clears the counter to 0. A flag that is already set stays set.
- R6: A result whose channel differs from `sel_ch` leaves the counter unchanged. With `sel_ch` at 12 or above, no result is ever compared.
- R7: With `fmt_signed` at 1, the result and the reference are compared as 12-bit two's complement values: 0xFFF is -1, which is less than 0x000. With `fmt_signed` at 0, they are compared as unsigned values.
- R8: While `cmp_en` is 0, no comparison is made and the counter is held at 0.
- R9: Once the count has been reached, the counter saturates. Every further matching result on the selected channel sets the flag again, including right after a clear.
- R10: A `flag_w1c` pulse clears the flag. If a set event happens in the same cycle, the set wins and the flag stays 1.
- R11: `cmp_irq` is 1 exactly when the flag is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | One-cycle strobe: a conversion result is being loaded |
| res_ch | input | 4 | Channel index of the result |
| res_data | input | 12 | Conversion result |
| cmp_en | input | 1 | Compare enable |
| irq_en | input | 1 | Interrupt enable |
| cond_ge | input | 1 | Condition: 0 = less than, 1 = greater than or equal |
| sel_ch | input | 4 | Channel that is watched |
| match_cnt | input | 4 | Required consecutive matches minus one |
| ref_val | input | 12 | Reference value |
| fmt_signed | input | 1 | 1 = two's complement compare, 0 = unsigned |
| flag_w1c | input | 1 | Write-1 pulse that clears the flag |
| cmp_flag | output | 1 | Sticky compare flag |
| cmp_irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: the software clear of the flag and a hardware set event. The bench provokes the collision with `match_cnt` at 0. It drives a matching result on the selected channel and the `flag_w1c` pulse on the same clock edge. It then samples the flag half a cycle later and expects it to be 1. A following clear with no result present must then bring the flag to 0, which shows the clear path itself works.

// File: rtl/adc_match_monitor.sv
module adc_match_monitor #(
  parameter int RES_W  = 12,
  parameter int CH_W   = 4,
  parameter int CNT_W  = 4,
  parameter int NUM_CH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_vld,
  input  logic [CH_W-1:0]  res_ch,
  input  logic [RES_W-1:0] res_data,
  input  logic             cmp_en,
  input  logic             irq_en,
  input  logic             cond_ge,
  input  logic [CH_W-1:0]  sel_ch,
  input  logic [CNT_W-1:0] match_cnt,
  input  logic [RES_W-1:0] ref_val,
  input  logic             fmt_signed,
  input  logic             flag_w1c,
  output logic             cmp_flag,
  output logic             cmp_irq
);
  localparam int TGT_W = CNT_W + 1;

  logic [TGT_W-1:0] cnt;
  logic [TGT_W-1:0] target;
  logic             hit, below, match, reached, set_evt;

  assign target  = {1'b0, match_cnt} + TGT_W'(1);
  assign hit     = res_vld && cmp_en && (res_ch == sel_ch) &&
                   (32'(sel_ch) < NUM_CH);
  assign below   = fmt_signed ? ($signed(res_data) < $signed(ref_val))
                              : (res_data < ref_val);
  assign match   = cond_ge ? !below : below;
  assign reached = (cnt + TGT_W'(1)) >= target;
  assign set_evt = hit && match && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!cmp_en)
      cnt <= '0;
    else if (hit) begin
      if (!match)
        cnt <= '0;
      else if (cnt < target)
        cnt <= cnt + TGT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmp_flag <= 1'b0;
    else if (set_evt)
      cmp_flag <= 1'b1;
    else if (flag_w1c)
      cmp_flag <= 1'b0;
  end

  assign cmp_irq = cmp_flag && irq_en;

  // R5
  mismatch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && cmp_en && res_ch == sel_ch && !match) |=> (cnt == '0));

  // R6
  other_ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (!res_vld || res_ch != sel_ch)) |=> $stable(cnt));

  // R8
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> (cnt == '0));

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> (cmp_flag && irq_en));

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(res_vld && cmp_en && res_ch == sel_ch));

  // R10
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1c && !res_vld) |=> !cmp_flag);
endmodule

// File: tb/test_adc_match_monitor.sv
module test_adc_match_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_vld = 1'b0;
  logic [3:0]  res_ch = '0;
  logic [11:0] res_data = '0;
  logic        cmp_en = 1'b0;
  logic        irq_en = 1'b0;
  logic        cond_ge = 1'b0;
  logic [3:0]  sel_ch = '0;
  logic [3:0]  match_cnt = '0;
  logic [11:0] ref_val = '0;
  logic        fmt_signed = 1'b0;
  logic        flag_w1c = 1'b0;
  logic        cmp_flag, cmp_irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_match_monitor i_adc_match_monitor (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch),
    .res_data(res_data), .cmp_en(cmp_en), .irq_en(irq_en), .cond_ge(cond_ge),
    .sel_ch(sel_ch), .match_cnt(match_cnt), .ref_val(ref_val),
    .fmt_signed(fmt_signed), .flag_w1c(flag_w1c),
    .cmp_flag(cmp_flag), .cmp_irq(cmp_irq));

  // {channel[3:0], data[11:0], expected flag}; sel_ch=3, match_cnt=2, less than 0x800 unsigned
  localparam logic [16:0] VEC [8] = '{
    {4'd3, 12'h100, 1'b0},
    {4'd5, 12'h100, 1'b0},
    {4'd3, 12'h900, 1'b0},
    {4'd3, 12'h7FF, 1'b0},
    {4'd3, 12'h000, 1'b0},
    {4'd2, 12'hFFF, 1'b0},
    {4'd3, 12'h7FF, 1'b1},
    {4'd3, 12'h800, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] ch, input logic [11:0] d);
    @(negedge clk);
    res_vld = 1'b1; res_ch = ch; res_data = d;
    @(negedge clk);
    res_vld = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_w1c = 1'b1;
    @(negedge clk);
    flag_w1c = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag", cmp_flag, 1'b0);
    check("R1 irq", cmp_irq, 1'b0);
    rst_n = 1'b1;

    cmp_en = 1'b1; sel_ch = 4'd3; match_cnt = 4'd2; ref_val = 12'h800;
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][16:13], VEC[i][12:1]);
      check("R2/R4/R5/R6 table", cmp_flag, VEC[i][0]);
    end

    clear_flag();
    check("R10 clear", cmp_flag, 1'b0);

    match_cnt = 4'd0; cond_ge = 1'b1;
    push(4'd3, 12'h800);
    check("R3 equal", cmp_flag, 1'b1);
    clear_flag();
    push(4'd3, 12'h7FF);
    check("R3 below", cmp_flag, 1'b0);

    cond_ge = 1'b0; ref_val = 12'h000; fmt_signed = 1'b1;
    push(4'd3, 12'hFFF);
    check("R7 signed", cmp_flag, 1'b1);
    clear_flag();
    fmt_signed = 1'b0;
    push(4'd3, 12'hFFF);
    check("R7 unsigned", cmp_flag, 1'b0);

    ref_val = 12'h800; match_cnt = 4'd1;
    push(4'd3, 12'h010);
    @(negedge clk); cmp_en = 1'b0;
    push(4'd3, 12'h010);
    check("R8 disabled", cmp_flag, 1'b0);
    cmp_en = 1'b1;
    push(4'd3, 12'h010);
    check("R8 counter cleared", cmp_flag, 1'b0);
    push(4'd3, 12'h010);
    check("R8 counts again", cmp_flag, 1'b1);

    clear_flag();
    push(4'd3, 12'h010);
    check("R9 saturated reset", cmp_flag, 1'b1);

    clear_flag();
    sel_ch = 4'd12; match_cnt = 4'd0;
    push(4'd12, 12'h010);
    check("R6 sel out of range", cmp_flag, 1'b0);

    sel_ch = 4'd3;
    @(negedge clk);
    res_vld = 1'b1; res_ch = 4'd3; res_data = 12'h010; flag_w1c = 1'b1;
    @(negedge clk);
    res_vld = 1'b0; flag_w1c = 1'b0;
    check("R10 set wins", cmp_flag, 1'b1);

    irq_en = 1'b1; #1;
    check("R11 irq on", cmp_irq, 1'b1);
    irq_en = 1'b0; #1;
    check("R11 irq masked", cmp_irq, 1'b0);
    irq_en = 1'b1;
    clear_flag();
    check("R11 irq after clear", cmp_irq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule